// File: doc/BRIEF.md
# Snooping MESI Line Controller

This block keeps one small private, direct-mapped cache coherent with its peers on a shared snooping bus. Each line holds one data word and one of four coherence states: Invalid, Shared, Exclusive or Modified. The processor side presents a read or a write and holds it until it is acknowledged. The controller answers from the line, or fetches the line over the bus first, or upgrades it over the bus first. At the same time it watches every transaction that the other caches put on the bus and answers each one that hits a local line.

A snooped read that finds a line dirty is not served from this cache. The controller tells the requester to back off, writes the dirty word to main memory through a simple write port, and keeps the line as a Shared copy. The retried read is then served from memory, which now holds the current data. Dirty data otherwise goes to memory only when a miss evicts a Modified line. A parameter chooses whether a read fill with no other sharers enters Exclusive, or always enters Shared.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_ack`, `cpu_stall`, `bus_req`, `mem_wr_valid`, `snp_retry` and `snp_shared` are low. The first access to any address therefore misses.
- R2: A read miss requests the bus with command 0 (read) and the processor address. The line fills with `bus_rdata` as Exclusive when `bus_shared` is low at the grant, and as Shared when it is high.
- R3: A read that hits, while the controller is idle and no snoop is present, is acknowledged in the same cycle with the line's word on `cpu_rdata` and no bus request.
- R4: A write that hits an Exclusive or Modified line is acknowledged in the same cycle with no bus request, and leaves the line Modified and holding the written word.
- R5: A write that hits a Shared line first wins a bus transaction with command 2 (upgrade) at the line address, then completes as a write to a Modified line.
- R6: A write miss requests the bus with command 1 (read for ownership), fills the line as Modified from memory, and then applies the write.
- R7: A snooped read (command 0) that hits a Modified line raises `snp_retry` in that cycle and not `snp_shared`. If the controller is idle it then drives `mem_wr_valid` with the snooped address and the line's word, holds both until `mem_wr_ready`, and leaves the line Shared.
- R8: A snooped read that hits an Exclusive or Shared line raises `snp_shared` in that cycle, writes nothing to memory, and leaves the line Shared.
- R9: A snooped command 1 or 2 that hits an Exclusive or Shared line makes it Invalid with no write to memory. When it hits a Modified line, the controller raises `snp_retry`, writes the word back, and then makes the line Invalid.
- R10: A miss whose line slot holds a Modified line of another address writes that victim to memory first and only then requests the bus. A victim that is not Modified is dropped with no write. `bus_req` and `mem_wr_valid` are never high together.
- R11: A snoop that hits a Modified line while the controller is busy with a write-back or a bus transaction gets `snp_retry`, and the line's state and the write-back in progress are left unchanged.
- R12: A granted bus transaction answered with `bus_retry` is requested again, with the same command and address, until a grant without retry completes it.
- R13: `cpu_stall` is high exactly when `cpu_req` is high and `cpu_ack` is low. No local access is acknowledged in a cycle in which `snp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address; low bits select the line |
| cpu_wdata | input | DW | Write data |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_ack` on a read |
| cpu_stall | output | 1 | Request pending and not completing this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 read for ownership, 2 upgrade |
| bus_addr | output | AW | Bus transaction address |
| bus_gnt | input | 1 | Bus transaction takes place this cycle |
| bus_retry | input | 1 | With grant: another cache forced a back-off |
| bus_shared | input | 1 | With grant: another cache holds a copy |
| bus_rdata | input | DW | With grant: word from memory |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Snooped address |
| snp_retry | output | 1 | Back-off answer to the snooped transaction |
| snp_shared | output | 1 | Copy-held answer to the snooped read |
| mem_wr_valid | output | 1 | Write-back to memory pending |
| mem_wr_addr | output | AW | Write-back address |
| mem_wr_data | output | DW | Write-back word |
| mem_wr_ready | input | 1 | Memory accepts the write-back this cycle |

## Verification
The bench goes after the write-back paths. A dirty line hit by a snooped read must give back-off, one memory write of the latest word, and a later shared answer. A design that served the data directly or kept the line Modified would show a missing write or a second back-off. It checks that a Modified victim is written before the refill, and that a clean victim produces no memory write. A design that lost dirty data would return a stale word on the next read.

It forces a snoop onto a dirty line while an eviction is still waiting for memory, and checks that the eviction address does not move and that the dirty line still answers with back-off afterwards. It also checks that an upgrade is not mistaken for a fill, that a bus retry is followed by a new request, and that a hit and a snoop arriving together delay the hit rather than letting both update the line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } mesi_t;

   typedef enum logic [1:0] {
      CMD_RD  = 2'd0,
      CMD_RDX = 2'd1,
      CMD_UPG = 2'd2,
      CMD_NOP = 2'd3
   } bus_cmd_t;

   typedef enum logic [1:0] {
      FSM_IDLE = 2'd0,
      FSM_BUS  = 2'd1,
      FSM_WB   = 2'd2
   } fsm_t;
endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
(
   input  logic       valid,
   input  logic [1:0] cmd,
   input  logic       hit,
   input  mesi_t      st,
   input  logic       engine_free,
   output logic       retry,
   output logic       shared,
   output logic       upd,
   output mesi_t      nxt,
   output logic       wb_start,
   output mesi_t      wb_nxt
);
   logic is_rd, is_inv, act;

   assign is_rd    = (cmd == CMD_RD);
   assign is_inv   = (cmd == CMD_RDX) || (cmd == CMD_UPG);
   assign act      = valid && hit && (is_rd || is_inv);
   // dirty lines never hand data over: the requester backs off
   assign retry    = act && (st == ST_M);
   assign shared   = act && is_rd && ((st == ST_E) || (st == ST_S));
   // clean lines change state at once; a read leaves a Shared line alone
   assign upd      = act && (st != ST_M) && (is_inv || (st == ST_E));
   assign nxt      = is_inv ? ST_I : ST_S;
   assign wb_start = retry && engine_free;
   assign wb_nxt   = is_rd ? ST_S : ST_I;
endmodule

// File: rtl/mesi_fill_pick.sv
module mesi_fill_pick
   import mesi_pkg::*;
#(
   parameter bit USE_EXCL = 1'b1
) (
   input  logic [1:0] cmd,
   input  logic       peer_shared,
   output mesi_t      fill_st
);
   mesi_t clean_st;

   generate
      if (USE_EXCL) begin : g_excl
         assign clean_st = peer_shared ? ST_S : ST_E;
      end else begin : g_noexcl
         assign clean_st = ST_S;
      end
   endgenerate

   assign fill_st = (cmd == CMD_RDX) ? ST_M : clean_st;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 16,
   parameter int NLINES   = 4,
   parameter bit USE_EXCL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ack,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_stall,
   output logic          bus_req,
   output logic [1:0]    bus_cmd,
   output logic [AW-1:0] bus_addr,
   input  logic          bus_gnt,
   input  logic          bus_retry,
   input  logic          bus_shared,
   input  logic [DW-1:0] bus_rdata,
   input  logic          snp_valid,
   input  logic [1:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_retry,
   output logic          snp_shared,
   output logic          mem_wr_valid,
   output logic [AW-1:0] mem_wr_addr,
   output logic [DW-1:0] mem_wr_data,
   input  logic          mem_wr_ready
);
   localparam int IDXW = $clog2(NLINES);
   localparam int TAGW = AW - IDXW;

   generate
      if (NLINES < 2 || (NLINES & (NLINES - 1)) != 0) begin : g_bad_lines
         $error("NLINES must be a power of two of at least 2");
      end
      if (TAGW < 1) begin : g_bad_aw
         $error("AW must exceed the index width");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   mesi_t          st_q  [NLINES];
   logic [TAGW-1:0] tag_q [NLINES];
   logic [DW-1:0]  dat_q [NLINES];

   fsm_t           fsm_q;
   bus_cmd_t       pend_cmd_q;
   logic [AW-1:0]  pend_addr_q;
   logic [IDXW-1:0] wb_idx_q;
   logic [AW-1:0]  wb_addr_q;
   mesi_t          wb_nxt_q;

   logic [IDXW-1:0] c_idx, s_idx, p_idx;
   logic [TAGW-1:0] c_tag, s_tag;
   logic c_hit, s_hit, eng_idle, local_go, need_upg, miss;
   logic evict_go, fetch_go, upg_stale, bus_done, wb_done;
   logic s_upd, s_wb_start;
   mesi_t s_nxt, s_wb_nxt, fill_st;

   assign c_idx = cpu_addr[IDXW-1:0];
   assign c_tag = cpu_addr[AW-1:IDXW];
   assign s_idx = snp_addr[IDXW-1:0];
   assign s_tag = snp_addr[AW-1:IDXW];
   assign p_idx = pend_addr_q[IDXW-1:0];

   assign c_hit = (st_q[c_idx] != ST_I) && (tag_q[c_idx] == c_tag);
   assign s_hit = (st_q[s_idx] != ST_I) && (tag_q[s_idx] == s_tag);

   assign eng_idle = (fsm_q == FSM_IDLE);

   mesi_snoop_resp u_snoop (
      .valid       (snp_valid),
      .cmd         (snp_cmd),
      .hit         (s_hit),
      .st          (st_q[s_idx]),
      .engine_free (eng_idle),
      .retry       (snp_retry),
      .shared      (snp_shared),
      .upd         (s_upd),
      .nxt         (s_nxt),
      .wb_start    (s_wb_start),
      .wb_nxt      (s_wb_nxt)
   );

   mesi_fill_pick #(.USE_EXCL(USE_EXCL)) u_fill (
      .cmd         (pend_cmd_q),
      .peer_shared (bus_shared),
      .fill_st     (fill_st)
   );

   // local side: only when idle and the bus carries no foreign snoop
   assign local_go  = eng_idle && cpu_req && !snp_valid;
   assign cpu_ack   = local_go && c_hit &&
                      (!cpu_we || st_q[c_idx] == ST_M || st_q[c_idx] == ST_E);
   assign cpu_rdata = dat_q[c_idx];
   assign cpu_stall = cpu_req && !cpu_ack;
   assign need_upg  = local_go && c_hit && cpu_we && (st_q[c_idx] == ST_S);
   assign miss      = local_go && !c_hit;
   assign evict_go  = miss && (st_q[c_idx] == ST_M);
   assign fetch_go  = miss && (st_q[c_idx] != ST_M);

   // an upgrade whose Shared copy was invalidated meanwhile is abandoned
   assign upg_stale = (pend_cmd_q == CMD_UPG) && (st_q[p_idx] != ST_S);
   assign bus_req   = (fsm_q == FSM_BUS) && !upg_stale;
   assign bus_cmd   = pend_cmd_q;
   assign bus_addr  = pend_addr_q;
   assign bus_done  = bus_req && bus_gnt && !bus_retry;

   assign mem_wr_valid = (fsm_q == FSM_WB);
   assign mem_wr_addr  = wb_addr_q;
   assign mem_wr_data  = dat_q[wb_idx_q];
   assign wb_done      = mem_wr_valid && mem_wr_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q       <= FSM_IDLE;
         pend_cmd_q  <= CMD_RD;
         pend_addr_q <= '0;
         wb_idx_q    <= '0;
         wb_addr_q   <= '0;
         wb_nxt_q    <= ST_I;
      end else begin
         unique case (fsm_q)
            FSM_IDLE: begin
               if (s_wb_start) begin
                  fsm_q     <= FSM_WB;
                  wb_idx_q  <= s_idx;
                  wb_addr_q <= snp_addr;
                  wb_nxt_q  <= s_wb_nxt;
               end else if (evict_go) begin
                  fsm_q     <= FSM_WB;
                  wb_idx_q  <= c_idx;
                  wb_addr_q <= {tag_q[c_idx], c_idx};
                  wb_nxt_q  <= ST_I;
               end else if (need_upg) begin
                  fsm_q       <= FSM_BUS;
                  pend_cmd_q  <= CMD_UPG;
                  pend_addr_q <= cpu_addr;
               end else if (fetch_go) begin
                  fsm_q       <= FSM_BUS;
                  pend_cmd_q  <= cpu_we ? CMD_RDX : CMD_RD;
                  pend_addr_q <= cpu_addr;
               end
            end
            FSM_BUS: if (upg_stale || bus_done) fsm_q <= FSM_IDLE;
            FSM_WB:  if (mem_wr_ready) fsm_q <= FSM_IDLE;
            default: fsm_q <= FSM_IDLE;
         endcase
      end
   end

   // coherence state per line; write-back completion, then snoop, then bus, then local
   always_ff @(posedge clk) begin
      for (int i = 0; i < NLINES; i++) begin
         if (!rst_n) begin
            st_q[i] <= ST_I;
         end else if (wb_done && wb_idx_q == IDXW'(i)) begin
            st_q[i] <= wb_nxt_q;
         end else if (s_upd && s_idx == IDXW'(i)) begin
            st_q[i] <= s_nxt;
         end else if (bus_done && p_idx == IDXW'(i)) begin
            st_q[i] <= (pend_cmd_q == CMD_UPG) ? ST_M : fill_st;
         end else if (cpu_ack && cpu_we && c_idx == IDXW'(i)) begin
            st_q[i] <= ST_M;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NLINES; i++) begin
         if (bus_done && p_idx == IDXW'(i) && pend_cmd_q != CMD_UPG) begin
            tag_q[i] <= pend_addr_q[AW-1:IDXW];
            dat_q[i] <= bus_rdata;
         end else if (cpu_ack && cpu_we && c_idx == IDXW'(i)) begin
            dat_q[i] <= cpu_wdata;
         end
      end
   end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_req,
   input logic          cpu_ack,
   input logic          snp_valid,
   input logic [AW-1:0] snp_addr,
   input logic          snp_retry,
   input logic          snp_shared,
   input logic          bus_req,
   input logic [1:0]    bus_cmd,
   input logic [AW-1:0] bus_addr,
   input logic          bus_gnt,
   input logic          bus_retry,
   input logic          mem_wr_valid,
   input logic          mem_wr_ready,
   input logic [AW-1:0] mem_wr_addr,
   input logic [DW-1:0] mem_wr_data,
   input logic          eng_idle
);
   p_ack_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> (cpu_req && !snp_valid));

   p_resp_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(snp_retry && snp_shared));

   p_retry_starts_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_retry && eng_idle) |=> (mem_wr_valid && mem_wr_addr == $past(snp_addr)));

   p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

   p_single_activity_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && mem_wr_valid));

   p_retry_reissue_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_retry) |=>
         (bus_req && $stable(bus_addr) && $stable(bus_cmd)));

   p_busy_wb_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_retry && !eng_idle && mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr)));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_req      (cpu_req),
   .cpu_ack      (cpu_ack),
   .snp_valid    (snp_valid),
   .snp_addr     (snp_addr),
   .snp_retry    (snp_retry),
   .snp_shared   (snp_shared),
   .bus_req      (bus_req),
   .bus_cmd      (bus_cmd),
   .bus_addr     (bus_addr),
   .bus_gnt      (bus_gnt),
   .bus_retry    (bus_retry),
   .mem_wr_valid (mem_wr_valid),
   .mem_wr_ready (mem_wr_ready),
   .mem_wr_addr  (mem_wr_addr),
   .mem_wr_data  (mem_wr_data),
   .eng_idle     (eng_idle)
);

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NL = 4;
   localparam int NA = 1 << AW;
   localparam int SI = 0, SS = 1, SE = 2, SM = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic cpu_ack, cpu_stall;
   logic [DW-1:0] cpu_rdata;
   logic bus_req;
   logic [1:0] bus_cmd;
   logic [AW-1:0] bus_addr;
   logic bus_gnt = 0, bus_retry = 0, bus_shared = 0;
   logic [DW-1:0] bus_rdata = '0;
   logic snp_valid = 0;
   logic [1:0] snp_cmd = 2'd3;
   logic [AW-1:0] snp_addr = '0;
   logic snp_retry, snp_shared;
   logic mem_wr_valid;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic mem_wr_ready = 0;

   always #2.5 clk = ~clk;

   mesi_line_ctrl #(.AW(AW), .DW(DW), .NLINES(NL)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
      .bus_retry(bus_retry), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_retry(snp_retry), .snp_shared(snp_shared),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ready(mem_wr_ready)
   );

   // behavioural reference: per-address coherence state, latest value, memory image
   int mst [NA];
   logic [DW-1:0] cur [NA];
   logic [DW-1:0] mem_m [NA];

   int n_chk = 0, n_fail = 0;
   int n_grant = 0, n_done = 0, n_memwr = 0;
   int retry_budget = 0, wb_delay = 2, wb_cnt = 0;
   bit share_flag = 0, finished = 0, ref_on = 0;
   logic [1:0] last_cmd = 2'd3;
   logic [AW-1:0] last_baddr = '0, last_waddr = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void set_line(input int a, input int s);
      for (int k = 0; k < NA; k++)
         if ((k % NL) == (a % NL)) mst[k] = SI;
      mst[a] = s;
   endfunction

   // every-cycle comparison against the reference, then the bus and memory responders
   always @(negedge clk) begin
      if (ref_on) begin
         check("R13 stall", cpu_stall, cpu_req && !cpu_ack);
         if (cpu_ack && !cpu_we) check("R3 read data", cpu_rdata, cur[cpu_addr]);
         if (snp_valid) begin
            check("R7/R9/R11 snoop retry", snp_retry,
                  (snp_cmd != 2'd3) && (mst[snp_addr] == SM));
            check("R8 snoop shared", snp_shared,
                  (snp_cmd == 2'd0) && (mst[snp_addr] == SE || mst[snp_addr] == SS));
         end
         if (bus_req && mem_wr_valid) check("R10 bus and write-back apart", 1, 0);
      end
      if (bus_req) begin
         bus_gnt = 1;
         bus_rdata = mem_m[bus_addr];
         bus_shared = share_flag;
         n_grant++;
         if (retry_budget > 0) begin
            bus_retry = 1;
            retry_budget--;
         end else begin
            bus_retry = 0;
            n_done++;
            last_cmd = bus_cmd;
            last_baddr = bus_addr;
         end
      end else begin
         bus_gnt = 0;
         bus_retry = 0;
      end
      if (mem_wr_valid) begin
         if (wb_cnt < wb_delay) begin
            wb_cnt++;
            mem_wr_ready = 0;
         end else begin
            wb_cnt = 0;
            mem_wr_ready = 1;
            n_memwr++;
            last_waddr = mem_wr_addr;
            check("R7/R10 write-back data", mem_wr_data, cur[mem_wr_addr]);
            mem_m[mem_wr_addr] = mem_wr_data;
         end
      end else begin
         wb_cnt = 0;
         mem_wr_ready = 0;
      end
   end

   task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         output int lat);
      @(posedge clk); #1;
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      lat = 0;
      forever begin
         @(negedge clk);
         if (cpu_ack) break;
         lat++;
         if (lat > 300) break;
      end
      @(posedge clk); #1;
      cpu_req = 0;
      if (we) begin
         cur[a] = wd;
         set_line(a, SM);
      end else if (mst[a] == SI) begin
         set_line(a, share_flag ? SS : SE);
      end
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (!mem_wr_valid && !bus_req) break;
      end
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a, input bit busy);
      @(posedge clk); #1;
      snp_valid = 1; snp_cmd = cmd; snp_addr = a;
      @(posedge clk); #1;
      snp_valid = 0; snp_cmd = 2'd3;
      if (mst[a] == SM) begin
         if (!busy) begin
            mst[a] = (cmd == 2'd0) ? SS : SI;
            wait_idle();
         end
      end else if (mst[a] != SI) begin
         mst[a] = (cmd == 2'd0) ? SS : SI;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int lat, lat2, g0, d0, w0;
      for (int i = 0; i < NA; i++) begin
         mem_m[i] = DW'(16'hA000 + i * 7);
         cur[i] = mem_m[i];
         mst[i] = SI;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check("R1 reset bus_req", bus_req, 0);
      check("R1 reset mem_wr_valid", mem_wr_valid, 0);
      check("R1 reset cpu_stall", cpu_stall, 0);
      check("R1 reset snoop answers", {snp_retry, snp_shared}, 0);
      ref_on = 1;

      // first read misses and fills Exclusive
      d0 = n_done;
      cpu_op(0, 8'h10, 0, lat);
      check("R1 first access misses", n_done - d0, 1);
      check("R2 read miss command", last_cmd, 0);
      check("R2 read miss address", last_baddr, 8'h10);

      g0 = n_grant;
      cpu_op(0, 8'h10, 0, lat);
      check("R3 hit latency", lat, 0);
      check("R3 hit has no bus use", n_grant - g0, 0);

      cpu_op(1, 8'h10, 16'h1111, lat);
      check("R4 write to Exclusive latency", lat, 0);
      check("R4 write to Exclusive no bus", n_grant - g0, 0);

      // snooped read on a dirty line: back-off, write-back, Shared
      w0 = n_memwr;
      snoop(2'd0, 8'h10, 0);
      check("R7 one write-back", n_memwr - w0, 1);
      check("R7 write-back address", last_waddr, 8'h10);
      snoop(2'd0, 8'h10, 0);
      check("R8 Shared line no write-back", n_memwr - w0, 1);

      cpu_op(1, 8'h10, 16'h2222, lat);
      check("R5 upgrade command", last_cmd, 2);
      check("R5 upgrade address", last_baddr, 8'h10);
      cpu_op(0, 8'h10, 0, lat);
      check("R5 line Modified after upgrade", lat, 0);

      // fill with a peer copy present enters Shared
      share_flag = 1;
      cpu_op(0, 8'h21, 0, lat);
      share_flag = 0;
      cpu_op(1, 8'h21, 16'h3333, lat);
      check("R2 shared fill needs upgrade", last_cmd, 2);

      // snooped read on Exclusive: shared answer, no write, now Shared
      cpu_op(0, 8'h32, 0, lat);
      w0 = n_memwr;
      snoop(2'd0, 8'h32, 0);
      check("R8 Exclusive no write-back", n_memwr - w0, 0);
      cpu_op(1, 8'h32, 16'h4444, lat);
      check("R8 Exclusive became Shared", last_cmd, 2);

      // snooped ownership read on Exclusive: Invalid, no write
      cpu_op(0, 8'h03, 0, lat);
      w0 = n_memwr;
      snoop(2'd1, 8'h03, 0);
      check("R9 clean invalidate no write-back", n_memwr - w0, 0);
      d0 = n_done;
      cpu_op(0, 8'h03, 0, lat);
      check("R9 line Invalid refetch", n_done - d0, 1);
      check("R9 refetch command", last_cmd, 0);

      // write miss over a dirty victim
      w0 = n_memwr;
      cpu_op(1, 8'h44, 16'h5555, lat);
      check("R10 dirty victim written", n_memwr - w0, 1);
      check("R10 victim address", last_waddr, 8'h10);
      check("R6 ownership read command", last_cmd, 1);
      check("R6 ownership read address", last_baddr, 8'h44);
      cpu_op(0, 8'h44, 0, lat);
      check("R6 write applied, hit", lat, 0);

      // snooped upgrade on Modified: back-off, write-back, Invalid
      w0 = n_memwr;
      snoop(2'd2, 8'h44, 0);
      check("R9 dirty invalidate write-back", n_memwr - w0, 1);
      check("R9 dirty invalidate address", last_waddr, 8'h44);
      cpu_op(0, 8'h44, 0, lat);
      check("R9 Invalid after write-back", last_cmd, 0);

      // clean victim dropped silently
      w0 = n_memwr;
      cpu_op(0, 8'h07, 0, lat);
      check("R10 clean victim no write", n_memwr - w0, 0);
      check("R10 clean victim refill address", last_baddr, 8'h07);

      // bus retries
      retry_budget = 2;
      g0 = n_grant; d0 = n_done;
      cpu_op(0, 8'h0B, 0, lat);
      check("R12 grants incl. retries", n_grant - g0, 3);
      check("R12 one completion", n_done - d0, 1);

      // snoop on a dirty line while an eviction waits for memory
      wb_delay = 8;
      fork
         cpu_op(0, 8'h3A, 0, lat2);
         begin
            for (int k = 0; k < 50; k++) begin
               @(negedge clk);
               if (mem_wr_valid) break;
            end
            snoop(2'd0, 8'h21, 1);
            @(negedge clk);
            check("R11 eviction still pending", mem_wr_valid, 1);
            check("R11 eviction address kept", mem_wr_addr, 8'h32);
         end
      join
      wb_delay = 2;
      w0 = n_memwr;
      snoop(2'd0, 8'h21, 0);
      check("R11 line stayed Modified", n_memwr - w0, 1);
      check("R11 later write-back address", last_waddr, 8'h21);

      // hit and snoop in the same cycle
      @(posedge clk); #1;
      cpu_req = 1; cpu_we = 0; cpu_addr = 8'h0B;
      snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h50;
      @(negedge clk);
      check("R13 no ack during snoop", cpu_ack, 0);
      @(posedge clk); #1;
      snp_valid = 0; snp_cmd = 2'd3;
      @(negedge clk);
      check("R13 ack after snoop", cpu_ack, 1);
      @(posedge clk); #1;
      cpu_req = 0;
      repeat (2) @(negedge clk);

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule